// File: doc/BRIEF.md
# Two-Branch Handshake Fork with Acknowledge Join

This block connects one four-phase producer to two four-phase consumers. The producer's request and its data word go to both consumers unchanged and without delay. The two consumer acknowledges are merged into a single acknowledge back to the producer.

The merged acknowledge is a registered agreement bit that behaves like a C-element. It goes high on the clock edge after both branches have acknowledged, and goes low on the edge after both branches have withdrawn their acknowledge. While the branches disagree it keeps its last value, so a fast branch cannot end a transfer before the slow one has finished.

A one-cycle completion flag marks the edge at which the merged acknowledge rises. The whole block is clocked on the rising edge and has a synchronous, active-high reset.

Top module: `hsk_fork2`

## Requirements
- R1: Each bit of `br_req` equals `src_req` in the same cycle, with no register in the path.
- R2: `br_data0` and `br_data1` both equal `src_data` in the same cycle, bit for bit.
- R3: While `rst` is high at a rising edge, `src_ack` and `xfer_done` are 0 after that edge.
- R4: If both bits of `br_ack` are 1 at a rising edge, `src_ack` is 1 after that edge.
- R5: If the two bits of `br_ack` differ at a rising edge, `src_ack` keeps its value across that edge. One early branch acknowledge therefore never raises it, and one early withdrawal never lowers it.
- R6: If both bits of `br_ack` are 0 at a rising edge, `src_ack` is 0 after that edge.
- R7: `xfer_done` is 1 for exactly the one cycle that follows an edge at which `src_ack` went from 0 to 1, and is 0 in every other cycle.
- R8: A synchronous reset given partway through a transfer returns `src_ack` to 0, even while both branch acknowledges are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | 1 | Request from the producer |
| src_data | input | DATA_W | Data word from the producer |
| src_ack | output | 1 | Merged acknowledge to the producer |
| br_req | output | 2 | Request copy for each branch (bit i goes to branch i) |
| br_data0 | output | DATA_W | Data copy for branch 0 |
| br_data1 | output | DATA_W | Data copy for branch 1 |
| br_ack | input | 2 | Acknowledge from each branch (bit i comes from branch i) |
| xfer_done | output | 1 | One-cycle flag marking the rise of `src_ack` |

## Verification
The assertions check the join rule on every cycle: `src_ack` rises after full agreement, falls after full withdrawal, and holds while the branches disagree. They also check that `xfer_done` appears only on the rise of `src_ack` and never lasts two cycles, and that reset clears both outputs.

The bench exercises every ordered pair of acknowledge patterns from both join states, and sweeps data patterns through both copies. Some behaviour only its scenarios can show: complete four-phase transfers where the branches answer and withdraw many cycles apart, and a reset applied in the middle of a transfer.

// File: rtl/hsk_fork2_pkg.sv
package hsk_fork2_pkg;

    localparam int unsigned BRANCHES = 2;

    typedef enum logic [1:0] {
        AGREE_NONE  = 2'b00,
        AGREE_SPLIT = 2'b01,
        AGREE_ALL   = 2'b10
    } agree_e;

    typedef struct packed {
        logic set_q;
        logic clr_q;
    } join_cmd_t;

    function automatic agree_e classify(input logic [BRANCHES-1:0] acks);
        if (&acks)       return AGREE_ALL;
        else if (~|acks) return AGREE_NONE;
        else             return AGREE_SPLIT;
    endfunction

    function automatic join_cmd_t decode_cmd(input agree_e a);
        join_cmd_t c;
        c.set_q = (a == AGREE_ALL);
        c.clr_q = (a == AGREE_NONE);
        return c;
    endfunction

endpackage

// File: rtl/hsk_req_fanout.sv
module hsk_req_fanout
    import hsk_fork2_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                       req_in,
    input  logic [DATA_W-1:0]          data_in,
    output logic [BRANCHES-1:0]        req_out,
    output logic [BRANCHES-1:0][DATA_W-1:0] data_out
);
    for (genvar g = 0; g < BRANCHES; g++) begin : g_branch
        assign req_out[g]  = req_in;
        assign data_out[g] = data_in;
    end
endmodule

// File: rtl/hsk_ack_join.sv
module hsk_ack_join
    import hsk_fork2_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [BRANCHES-1:0] acks,
    output logic                joined,
    output logic                rise
);
    agree_e    state_a;
    join_cmd_t cmd;
    logic      joined_q;
    logic      rise_q;

    always_comb begin
        state_a = classify(acks);
        cmd     = decode_cmd(state_a);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            joined_q <= 1'b0;
            rise_q   <= 1'b0;
        end else begin
            if (cmd.set_q)      joined_q <= 1'b1;
            else if (cmd.clr_q) joined_q <= 1'b0;
            rise_q <= cmd.set_q && !joined_q;
        end
    end

    assign joined = joined_q;
    assign rise   = rise_q;

    p_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (&acks) |=> joined_q);
    p_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (~|acks) |=> !joined_q);
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (acks[0] != acks[1]) |=> $stable(joined_q));
    p_done_edge_r7: assert property (@(posedge clk) disable iff (rst)
        rise_q |-> (joined_q && !$past(joined_q)));
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        rise_q |=> !rise_q);
    p_reset_r3: assert property (@(posedge clk)
        rst |=> (!joined_q && !rise_q));
endmodule

// File: rtl/hsk_fork2.sv
module hsk_fork2
    import hsk_fork2_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_req,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ack,
    output logic [1:0]        br_req,
    output logic [DATA_W-1:0] br_data0,
    output logic [DATA_W-1:0] br_data1,
    input  logic [1:0]        br_ack,
    output logic              xfer_done
);
    logic [BRANCHES-1:0][DATA_W-1:0] copies;

    hsk_req_fanout #(.DATA_W(DATA_W)) u_fanout (
        .req_in  (src_req),
        .data_in (src_data),
        .req_out (br_req),
        .data_out(copies)
    );

    assign br_data0 = copies[0];
    assign br_data1 = copies[1];

    hsk_ack_join u_join (
        .clk   (clk),
        .rst   (rst),
        .acks  (br_ack),
        .joined(src_ack),
        .rise  (xfer_done)
    );

    p_fan_r1: assert property (@(posedge clk) disable iff (rst)
        (br_req[0] == br_req[1]));
    p_copy_r2: assert property (@(posedge clk) disable iff (rst)
        (br_data0 == br_data1));
endmodule

// File: tb/hsk_fork2_tb.sv
module hsk_fork2_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         src_req = 1'b0;
    logic [W-1:0] src_data = '0;
    logic         src_ack;
    logic [1:0]   br_req;
    logic [W-1:0] br_data0, br_data1;
    logic [1:0]   br_ack = 2'b00;
    logic         xfer_done;

    int checks = 0;
    int errors = 0;
    logic exp_ack = 1'b0;
    logic exp_done = 1'b0;

    hsk_fork2 #(.DATA_W(W)) u_dut (
        .clk(clk), .rst(rst), .src_req(src_req), .src_data(src_data),
        .src_ack(src_ack), .br_req(br_req), .br_data0(br_data0),
        .br_data1(br_data1), .br_ack(br_ack), .xfer_done(xfer_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at negedge, check fan-out, clock once, check join state.
    task automatic step(input logic req, input logic [W-1:0] d, input logic [1:0] a,
                        input string tag);
        src_req = req; src_data = d; br_ack = a;
        #1;
        check("R1 br_req", {30'd0, br_req}, {30'd0, req, req});
        check("R2 br_data0", {24'd0, br_data0}, {24'd0, d});
        check("R2 br_data1", {24'd0, br_data1}, {24'd0, d});
        @(posedge clk);
        exp_done = (a == 2'b11) && !exp_ack;
        if (a == 2'b11) exp_ack = 1'b1;
        else if (a == 2'b00) exp_ack = 1'b0;
        @(negedge clk);
        check(tag, {31'd0, src_ack}, {31'd0, exp_ack});
        check("R7 xfer_done", {31'd0, xfer_done}, {31'd0, exp_done});
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R3 src_ack reset", {31'd0, src_ack}, 32'd0);
        check("R3 xfer_done reset", {31'd0, xfer_done}, 32'd0);
        rst = 1'b0;

        // Exhaustive ordered pairs of acknowledge patterns, from both join states.
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 4; p++) begin
                for (int q = 0; q < 4; q++) begin
                    step(1'b1, W'(p*16+q), s ? 2'b11 : 2'b00, "R4/R6 preset");
                    step(1'b1, W'(q*16+p), 2'(p), "R4/R5/R6 first");
                    step(1'b0, W'(~(p*16+q)), 2'(q), "R4/R5/R6 second");
                end
            end
        end

        // Data sweep through both copies.
        for (int v = 0; v < 256; v += 17) step(v[0], W'(v), 2'b00, "R6 idle");

        // Staggered four-phase transfer: branch 0 early, branch 1 late.
        step(1'b1, 8'hA5, 2'b01, "R5 early branch0 no rise");
        for (int k = 0; k < 5; k++) step(1'b1, 8'hA5, 2'b01, "R5 wait branch1");
        step(1'b1, 8'hA5, 2'b11, "R4 both ack");
        step(1'b0, 8'hA5, 2'b11, "R4 hold high");
        step(1'b0, 8'hA5, 2'b10, "R5 early withdraw");
        for (int k = 0; k < 4; k++) step(1'b0, 8'hA5, 2'b10, "R5 wait withdraw");
        step(1'b0, 8'hA5, 2'b00, "R6 both low");

        // Reset in mid-transfer.
        step(1'b1, 8'h3C, 2'b11, "R4 before reset");
        rst = 1'b1; br_ack = 2'b11;
        @(posedge clk); @(negedge clk);
        check("R8 mid reset ack", {31'd0, src_ack}, 32'd0);
        check("R8 mid reset done", {31'd0, xfer_done}, 32'd0);
        rst = 1'b0; exp_ack = 1'b0;
        step(1'b1, 8'h3C, 2'b11, "R8 rise after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule